// File: doc/BRIEF.md
# BCD Calendar with Century Bit

This block keeps the time of day and the calendar date in packed BCD and moves forward by one second on each pulse of a one-second tick. It holds seconds, minutes, 24-hour hours, day of week, date of month, month and a two-digit year. The hours byte also carries a century-enable flag and a century flag, and the seconds byte carries a stored oscillator-disable flag.

A bus interface elsewhere on the chip writes any of the seven bytes through a parallel load port: a strobe, a register index and a data byte. All seven bytes are always visible on the outputs, so an interface can take a snapshot of them at any time. A one-cycle midnight pulse marks the cycle in which the clock first shows 00:00:00 after rolling over from 23:59:59.

The tick source, the serial interface and any checking of nonsense written values are outside this block. After such a write the behaviour is undefined.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00 (century-enable 0, century 0), day 01, date 01, month 01 and year 00, and midnight is 0.
- R2: Each cycle with the tick high and no write advances the seconds in BCD from 00 to 59, then back to 00 with a carry into the minutes. A cycle with neither a tick nor a write leaves every output unchanged.
- R3: Minutes count 00 to 59 and carry into the hours. The hours (byte bits 5:0) count 00 to 23 and wrap to 00 at midnight.
- R4: The day of week (values 1 to 7) advances by one at each midnight and goes from 7 back to 1.
- R5: At midnight the date moves past the last day of the current month to 01 and the month advances. Months 01, 03, 05, 07, 08, 10 and 12 end on 31; months 04, 06, 09 and 11 end on 30.
- R6: February ends on 29 when the BCD year, read as a decimal number, is divisible by 4 (00 counts as a leap year), and on 28 otherwise. For example, year 10 is not a leap year and year 12 is.
- R7: Month 12 rolls over to 01 with a carry into the year, and the year rolls over from 99 to 00.
- R8: The hours byte holds century-enable in bit 7 and the century flag in bit 6. When the year rolls over from 99 to 00, the century flag toggles if century-enable is 1 and holds its value if century-enable is 0.
- R9: A write with index 0 to 6 loads seconds, minutes, hours, day, date, month or year in that order, and the new value shows on the outputs the next cycle. A write with index 7 changes nothing. Bits with no meaning read 0: minutes bit 7, day bits 7:3, date bits 7:6 and month bits 7:5.
- R10: When a write and a tick arrive in the same cycle, only the write takes effect. The tick is dropped and causes no carry.
- R11: Bit 7 of the seconds byte is a stored oscillator-disable flag that resets to 0. It is written with the seconds and keeps its value while the seconds count.
- R12: The midnight output is high for exactly one cycle: the cycle after the tick that moves 23:59:59 to 00:00:00, in which the outputs first show the new day.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| secTick | input | 1 | One-second advance pulse, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 3 | Index of the register to write (0 = seconds to 6 = year) |
| wrData | input | 8 | Byte to write |
| secReg | output | 8 | Oscillator-disable flag and BCD seconds |
| minReg | output | 8 | BCD minutes |
| hourReg | output | 8 | Century-enable, century flag and BCD hours |
| dowReg | output | 8 | Day of week, 1 to 7 |
| dateReg | output | 8 | BCD date of month |
| monReg | output | 8 | BCD month |
| yearReg | output | 8 | BCD year |
| midnight | output | 1 | One-cycle pulse on rollover to a new day |

## Verification
The rare cases are the month and year ends: a February in a leap year, a February in a year whose BCD byte is divisible by 4 as a binary number but not as a decimal one, and a December 31 with year 99 under each setting of century-enable. Counting up to these points would take millions of ticks. The bench instead writes the registers to one second before the boundary and then sends a single tick. It also sends a write and a tick in the same cycle while the seconds read 59, so that a lost tick shows up as an unchanged minute.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 3;
  localparam int NUM_REGS  = 7;

  typedef enum logic [IDX_W-1:0] {
    IDX_SEC  = 3'd0,
    IDX_MIN  = 3'd1,
    IDX_HOUR = 3'd2,
    IDX_DOW  = 3'd3,
    IDX_DATE = 3'd4,
    IDX_MON  = 3'd5,
    IDX_YEAR = 3'd6,
    IDX_NONE = 3'd7
  } regIdx_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic stepSec;
    logic wrapSec;
    logic stepMin;
    logic wrapMin;
    logic stepHour;
    logic wrapHour;
    logic stepDay;
    logic wrapDow;
    logic wrapDate;
    logic stepMon;
    logic wrapMon;
    logic stepYear;
    logic wrapYear;
    logic flipCent;
  } calStrobe_t;

  // add one to a two-digit packed BCD value (no wrap handling)
  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // decimal value 10*t + o is divisible by 4 exactly when 2*t + o is
  function automatic logic bcdLeap(input logic [BYTE_W-1:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [BYTE_W-1:0] monthEnd(input logic [BYTE_W-1:0] m,
                                                  input logic leap);
    logic [BYTE_W-1:0] r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int DOW_LAST = 7
) (
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] secQ,
  input  logic [BYTE_W-1:0] minQ,
  input  logic [BYTE_W-1:0] hourQ,
  input  logic [BYTE_W-1:0] dowQ,
  input  logic [BYTE_W-1:0] dateQ,
  input  logic [BYTE_W-1:0] monQ,
  input  logic [BYTE_W-1:0] yearQ,
  output calStrobe_t        stb
);

  localparam logic [BYTE_W-1:0] DOW_END = BYTE_W'(DOW_LAST);

  logic tickGo;
  logic secAtEnd, minAtEnd, hourAtEnd, dateAtEnd, monAtEnd, yearAtEnd;
  logic leapYear;

  // a write in the same cycle swallows the tick
  assign tickGo    = secTick && !wrEn;

  assign secAtEnd  = (secQ[6:0] == 7'h59);
  assign minAtEnd  = (minQ == 8'h59);
  assign hourAtEnd = (hourQ[5:0] == 6'h23);
  assign leapYear  = bcdLeap(yearQ);
  assign dateAtEnd = (dateQ == monthEnd(monQ, leapYear));
  assign monAtEnd  = (monQ == 8'h12);
  assign yearAtEnd = (yearQ == 8'h99);

  always_comb begin
    stb          = '0;
    stb.stepSec  = tickGo;
    stb.wrapSec  = secAtEnd;
    stb.stepMin  = tickGo && secAtEnd;
    stb.wrapMin  = minAtEnd;
    stb.stepHour = stb.stepMin && minAtEnd;
    stb.wrapHour = hourAtEnd;
    stb.stepDay  = stb.stepHour && hourAtEnd;
    stb.wrapDow  = (dowQ == DOW_END);
    stb.wrapDate = dateAtEnd;
    stb.stepMon  = stb.stepDay && dateAtEnd;
    stb.wrapMon  = monAtEnd;
    stb.stepYear = stb.stepMon && monAtEnd;
    stb.wrapYear = yearAtEnd;
    stb.flipCent = stb.stepYear && yearAtEnd && hourQ[7];
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int DOW_FIRST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BYTE_W-1:0] wrData,
  input  calStrobe_t        stb,
  output logic [BYTE_W-1:0] secQ,
  output logic [BYTE_W-1:0] minQ,
  output logic [BYTE_W-1:0] hourQ,
  output logic [BYTE_W-1:0] dowQ,
  output logic [BYTE_W-1:0] dateQ,
  output logic [BYTE_W-1:0] monQ,
  output logic [BYTE_W-1:0] yearQ,
  output logic              midnightQ
);

  localparam logic [BYTE_W-1:0] DOW_INIT = BYTE_W'(DOW_FIRST);

  logic [BYTE_W-1:0] secInc, minInc, hourInc, dateInc, monInc, yearInc;
  logic [BYTE_W-1:0] secN, minN, hourN, dowN, dateN, monN, yearN;

  assign secInc  = bcdInc({1'b0, secQ[6:0]});
  assign minInc  = bcdInc(minQ);
  assign hourInc = bcdInc({2'b00, hourQ[5:0]});
  assign dateInc = bcdInc(dateQ);
  assign monInc  = bcdInc(monQ);
  assign yearInc = bcdInc(yearQ);

  always_comb begin
    secN  = secQ;
    minN  = minQ;
    hourN = {hourQ[7], hourQ[6] ^ stb.flipCent, hourQ[5:0]};
    dowN  = dowQ;
    dateN = dateQ;
    monN  = monQ;
    yearN = yearQ;
    if (stb.stepSec)  secN  = {secQ[7], stb.wrapSec ? 7'h00 : secInc[6:0]};
    if (stb.stepMin)  minN  = stb.wrapMin ? 8'h00 : minInc;
    if (stb.stepHour) hourN[5:0] = stb.wrapHour ? 6'h00 : hourInc[5:0];
    if (stb.stepDay) begin
      dowN  = stb.wrapDow ? DOW_INIT : dowQ + 8'd1;
      dateN = stb.wrapDate ? 8'h01 : dateInc;
    end
    if (stb.stepMon)  monN  = stb.wrapMon ? 8'h01 : monInc;
    if (stb.stepYear) yearN = stb.wrapYear ? 8'h00 : yearInc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      secQ      <= 8'h00;
      minQ      <= 8'h00;
      hourQ     <= 8'h00;
      dowQ      <= DOW_INIT;
      dateQ     <= 8'h01;
      monQ      <= 8'h01;
      yearQ     <= 8'h00;
      midnightQ <= 1'b0;
    end else begin
      midnightQ <= stb.stepDay;
      if (wrEn) begin
        case (regIdx_e'(wrIdx))
          IDX_SEC:  secQ  <= wrData;
          IDX_MIN:  minQ  <= {1'b0, wrData[6:0]};
          IDX_HOUR: hourQ <= wrData;
          IDX_DOW:  dowQ  <= {5'b0, wrData[2:0]};
          IDX_DATE: dateQ <= {2'b0, wrData[5:0]};
          IDX_MON:  monQ  <= {3'b0, wrData[4:0]};
          IDX_YEAR: yearQ <= wrData;
          default:  ;
        endcase
      end else begin
        secQ  <= secN;
        minQ  <= minN;
        hourQ <= hourN;
        dowQ  <= dowN;
        dateQ <= dateN;
        monQ  <= monN;
        yearQ <= yearN;
      end
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DOW_FIRST = 1,
  parameter int DOW_LAST  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       secTick,
  input  logic       wrEn,
  input  logic [2:0] wrIdx,
  input  logic [7:0] wrData,
  output logic [7:0] secReg,
  output logic [7:0] minReg,
  output logic [7:0] hourReg,
  output logic [7:0] dowReg,
  output logic [7:0] dateReg,
  output logic [7:0] monReg,
  output logic [7:0] yearReg,
  output logic       midnight
);

  calStrobe_t stb;

  rtc_cal_ctrl #(.DOW_LAST(DOW_LAST)) u_ctrl (
    .secTick (secTick),
    .wrEn    (wrEn),
    .secQ    (secReg),
    .minQ    (minReg),
    .hourQ   (hourReg),
    .dowQ    (dowReg),
    .dateQ   (dateReg),
    .monQ    (monReg),
    .yearQ   (yearReg),
    .stb     (stb)
  );

  rtc_cal_datapath #(.DOW_FIRST(DOW_FIRST)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .stb       (stb),
    .secQ      (secReg),
    .minQ      (minReg),
    .hourQ     (hourReg),
    .dowQ      (dowReg),
    .dateQ     (dateReg),
    .monQ      (monReg),
    .yearQ     (yearReg),
    .midnightQ (midnight)
  );

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
  input logic       clk,
  input logic       rst,
  input logic       secTick,
  input logic       wrEn,
  input logic [2:0] wrIdx,
  input logic [7:0] wrData,
  input logic [7:0] secReg,
  input logic [7:0] minReg,
  input logic [7:0] hourReg,
  input logic [7:0] dowReg,
  input logic [7:0] dateReg,
  input logic [7:0] monReg,
  input logic [7:0] yearReg,
  input logic       midnight
);

  logic [55:0] allRegs;
  assign allRegs = {secReg, minReg, hourReg, dowReg, dateReg, monReg, yearReg};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!secTick && !wrEn) |=> ($stable(allRegs) && !midnight)); // R2

  AST_SEC_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx == 3'd0) |=> (secReg == $past(wrData))); // R9

  AST_SPARE_INDEX: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx == 3'd7) |=> $stable(allRegs)); // R9

  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx != 3'd0) |=> $stable(secReg)); // R10

  AST_OSC_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> (secReg[7] == $past(secReg[7]))); // R11

  AST_CENTURY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !hourReg[7]) |=> (hourReg[6] == $past(hourReg[6]))); // R8

  AST_MIDNIGHT_ZERO: assert property (@(posedge clk) disable iff (rst)
    midnight |-> (secReg[6:0] == 7'h00 && minReg == 8'h00 && hourReg[5:0] == 6'h00)); // R12

  AST_MIDNIGHT_PULSE: assert property (@(posedge clk) disable iff (rst)
    midnight |=> !midnight); // R12

endmodule

bind rtc_calendar rtc_cal_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .secTick  (secTick),
  .wrEn     (wrEn),
  .wrIdx    (wrIdx),
  .wrData   (wrData),
  .secReg   (secReg),
  .minReg   (minReg),
  .hourReg  (hourReg),
  .dowReg   (dowReg),
  .dateReg  (dateReg),
  .monReg   (monReg),
  .yearReg  (yearReg),
  .midnight (midnight)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;

  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic secTick = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] secReg, minReg, hourReg, dowReg, dateReg, monReg, yearReg;
  logic midnight;

  rtc_calendar uut (
    .clk(clk), .rst(rst), .secTick(secTick), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .secReg(secReg), .minReg(minReg), .hourReg(hourReg),
    .dowReg(dowReg), .dateReg(dateReg), .monReg(monReg), .yearReg(yearReg),
    .midnight(midnight)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // reference model, decimal fields
  int mSec = 0, mMin = 0, mHr = 0, mDow = 1, mDate = 1, mMon = 1, mYr = 0;
  bit mOsc = 0, mCen = 0, mCb = 0, mMid = 0;

  int          dueQ[$];
  logic [56:0] expQ[$];
  string       tagQ[$];

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int fromBcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int daysIn(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [56:0] modelVec();
    logic [7:0] s, h;
    s = toBcd(mSec);
    s[7] = mOsc;
    h = toBcd(mHr);
    h[7] = mCen;
    h[6] = mCb;
    return {mMid, s, toBcd(mMin), h, 8'(mDow), toBcd(mDate), toBcd(mMon), toBcd(mYr)};
  endfunction

  function automatic logic [56:0] dutVec();
    return {midnight, secReg, minReg, hourReg, dowReg, dateReg, monReg, yearReg};
  endfunction

  task automatic check(string tag, logic [56:0] got, logic [56:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHr++;
        if (mHr == 24) begin
          mHr = 0;
          mMid = 1;
          mDow = (mDow == 7) ? 1 : mDow + 1;
          mDate++;
          if (mDate > daysIn(mMon, mYr)) begin
            mDate = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYr++;
              if (mYr == 100) begin
                mYr = 0;
                if (mCen) mCb = ~mCb;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic modelWrite(logic [2:0] idx, logic [7:0] d);
    case (idx)
      3'd0: begin mOsc = d[7]; mSec = fromBcd({1'b0, d[6:0]}); end
      3'd1: mMin = fromBcd({1'b0, d[6:0]});
      3'd2: begin mCen = d[7]; mCb = d[6]; mHr = fromBcd({2'b0, d[5:0]}); end
      3'd3: mDow = int'(d[2:0]);
      3'd4: mDate = fromBcd({2'b0, d[5:0]});
      3'd5: mMon = fromBcd({3'b0, d[4:0]});
      3'd6: mYr = fromBcd(d);
      default: ;
    endcase
  endtask

  // driver: one operation per cycle, expected result pushed to scoreboard
  task automatic op(bit we, logic [2:0] idx, logic [7:0] d, bit tk, string tag);
    @(negedge clk);
    #1;
    wrEn = we; wrIdx = idx; wrData = d; secTick = tk;
    mMid = 0;
    if (we) modelWrite(idx, d);
    else if (tk) modelTick();
    dueQ.push_back(cyc);
    expQ.push_back(modelVec());
    tagQ.push_back(tag);
  endtask

  task automatic tick(string tag);
    op(1'b0, 3'd0, 8'h00, 1'b1, tag);
  endtask

  task automatic wr(logic [2:0] idx, logic [7:0] d, string tag);
    op(1'b1, idx, d, 1'b0, tag);
  endtask

  task automatic idle(string tag);
    op(1'b0, 3'd0, 8'h00, 1'b0, tag);
  endtask

  task automatic setDay(logic [7:0] y, logic [7:0] m, logic [7:0] dt, string tag);
    wr(3'd6, y, tag);
    wr(3'd5, m, tag);
    wr(3'd4, dt, tag);
  endtask

  task automatic lastSecond(logic [7:0] hourByte, string tag);
    wr(3'd2, hourByte, tag);
    wr(3'd1, 8'h59, tag);
    wr(3'd0, 8'h59, tag);
  endtask

  // monitor: compare outputs at the falling edge when an item falls due
  always @(negedge clk) begin
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      void'(dueQ.pop_front());
      check(tagQ.pop_front(), dutVec(), expQ.pop_front());
    end
    cyc++;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 reset values", dutVec(), modelVec());

    // R2 second counting and hold
    tick("R2 tick 1");
    tick("R2 tick 2");
    tick("R2 tick 3");
    idle("R2 hold without tick");
    wr(3'd0, 8'h58, "R9 write seconds");
    tick("R2 seconds to 59");
    tick("R2 seconds wrap carry minute");

    // R3 minute to hour carry
    wr(3'd1, 8'h59, "R9 write minutes");
    wr(3'd0, 8'h59, "R9 write seconds");
    tick("R3 minute carry into hour");

    // R4 R12 midnight with day 7 wrap
    wr(3'd3, 8'h07, "R9 write day");
    lastSecond(8'h23, "R9 preset");
    tick("R3 R4 R12 midnight rollover");
    idle("R12 pulse ends");

    // R5 month lengths
    setDay(8'h23, 8'h04, 8'h30, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R5 april 30 to may 1");
    setDay(8'h23, 8'h01, 8'h31, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R5 january 31 to february 1");
    setDay(8'h23, 8'h05, 8'h30, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R5 may 30 to may 31");

    // R6 leap years
    setDay(8'h24, 8'h02, 8'h28, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R6 leap 24 feb 28 to 29");
    lastSecond(8'h23, "R9 preset");
    tick("R6 leap 24 feb 29 to mar 1");
    setDay(8'h23, 8'h02, 8'h28, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R6 year 23 feb 28 to mar 1");
    setDay(8'h10, 8'h02, 8'h28, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R6 year 10 not leap");
    setDay(8'h00, 8'h02, 8'h28, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R6 year 00 is leap");

    // R7 R8 year and century
    setDay(8'h99, 8'h12, 8'h31, "R9 preset");
    lastSecond(8'hA3, "R9 preset");
    tick("R7 R8 year wrap toggles century");
    setDay(8'h99, 8'h12, 8'h31, "R9 preset");
    lastSecond(8'h63, "R9 preset");
    tick("R8 century held when disabled");
    setDay(8'h41, 8'h12, 8'h31, "R9 preset");
    lastSecond(8'h23, "R9 preset");
    tick("R7 december to january year carry");

    // R9 spare index and masks
    wr(3'd7, 8'h55, "R9 index 7 ignored");
    wr(3'd1, 8'h85, "R9 minute bit 7 masked");
    wr(3'd3, 8'hFE, "R9 day upper bits masked");
    wr(3'd4, 8'hD5, "R9 date upper bits masked");
    wr(3'd5, 8'hE9, "R9 month upper bits masked");

    // R10 write wins over tick
    wr(3'd0, 8'h59, "R9 preset");
    op(1'b1, 3'd1, 8'h10, 1'b1, "R10 write with tick drops tick");
    op(1'b1, 3'd0, 8'h30, 1'b1, "R10 seconds write with tick");

    // R11 oscillator flag kept while counting
    wr(3'd0, 8'hD9, "R11 write flag with 59");
    tick("R11 flag kept over wrap");
    tick("R11 flag kept over step");

    idle("R2 final hold");
    while (dueQ.size() > 0) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule